// File: doc/BRIEF.md
# Transmit Statistics Event Classifier

This block sits between a MAC transmit engine and a bank of transmit statistics counters. Each time a frame finishes, the MAC presents a one-cycle completion record. The record holds the outcome, the total collision count (late ones included), the deferral flags, the carrier-loss flag, the first destination address byte and the byte length. In that same cycle the block turns the record into one increment strobe per statistic, plus an amount for the octet counter.

Late collisions are counted as they happen, not per frame. The MAC pulses a separate event input for each late collision, and the block forwards each pulse as a strobe. A frame with several late collisions therefore raises that statistic several times. Loss of carrier never makes a frame an error: such a frame still counts as sent successfully, and it also raises the carrier-sense-error statistic. The block is purely combinational from record to strobes, so the counters can sit on the same clock with no alignment stage.

Top module: `txstat_classifier`

## Requirements
- R1: A valid record with outcome code 2'b00 (success) raises `inc_frames_ok` in the same cycle, whether or not `rec_carrier_lost` is set; codes 2'b01, 2'b10 and 2'b11 do not raise it.
- R2: `inc_bcast_ok` rises only for a successful record whose first destination byte is 8'hFF. `inc_mcast_ok` rises only for a successful record whose first byte has bit 0 set and is not 8'hFF. The two never rise together.
- R3: For a successful record, `inc_octets_ok` is high and `octet_amount` equals `rec_len`. Otherwise `inc_octets_ok` is low and `octet_amount` is zero.
- R4: `inc_single_coll` rises only for a successful record whose `rec_coll_cnt` is exactly 1.
- R5: `inc_multi_coll` rises only for a successful record whose `rec_coll_cnt` lies from 2 through 15. A count of 16 or more raises neither collision strobe.
- R6: `inc_late_coll` follows `late_coll_evt` in the same cycle, once per pulse, whether or not a record is valid.
- R7: A valid record with outcome code 2'b01 (aborted for excessive collisions) raises `inc_xs_coll_abort`. No other code raises it.
- R8: `inc_carrier_err` rises only for a successful record with `rec_carrier_lost` set.
- R9: `inc_deferred` and `inc_excess_defer` follow `rec_deferred` and `rec_excess_defer` for any valid record, whatever its outcome.
- R10: While `rec_valid` is low, every strobe except `inc_late_coll` stays low and `octet_amount` is zero, whatever the other record fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, gates the embedded checks |
| rec_valid | input | 1 | Completion record valid for this cycle |
| rec_outcome | input | 2 | 00 success, 01 excessive-collision abort, 10/11 other error |
| rec_coll_cnt | input | COLL_W (5) | Collisions seen by the frame, late ones included |
| rec_deferred | input | 1 | First attempt was deferred |
| rec_excess_defer | input | 1 | Deferral lasted too long |
| rec_carrier_lost | input | 1 | Carrier was lost during the frame |
| rec_dst_byte0 | input | 8 | First byte of the destination address |
| rec_len | input | LEN_W (16) | Frame length in bytes |
| late_coll_evt | input | 1 | Pulse per late collision as it occurs |
| inc_frames_ok | output | 1 | Frame sent successfully |
| inc_bcast_ok | output | 1 | Successful broadcast frame |
| inc_mcast_ok | output | 1 | Successful multicast frame |
| inc_octets_ok | output | 1 | Add `octet_amount` to the octet counter |
| octet_amount | output | LEN_W (16) | Bytes to add |
| inc_single_coll | output | 1 | Successful frame with one collision |
| inc_multi_coll | output | 1 | Successful frame with 2 to 15 collisions |
| inc_late_coll | output | 1 | One late collision |
| inc_xs_coll_abort | output | 1 | Frame aborted for excessive collisions |
| inc_carrier_err | output | 1 | Successful frame with carrier loss |
| inc_deferred | output | 1 | Frame deferred on first attempt |
| inc_excess_defer | output | 1 | Frame deferred excessively |

## Verification
The records sent cover every outcome code combined with carrier loss set and clear. This shows that carrier loss changes only the carrier-error strobe and never the success strobes. Collision counts of 0, 1, 2, 15 and 16 probe both edges of the single and multiple bins, each paired with a success and an abort outcome. Destination bytes FF, 01, FE and 00 separate broadcast, multicast and unicast, including the group bit on a non-broadcast address. Late-collision pulses are sent with no record and in back-to-back cycles, and records with every field set are held while valid is low, to show that only the late strobe moves.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  typedef enum logic [1:0] {
    OUT_OK      = 2'b00,
    OUT_XS_COLL = 2'b01,
    OUT_ERR_A   = 2'b10,
    OUT_ERR_B   = 2'b11
  } tx_outcome_e;

  typedef enum logic [1:0] {
    DST_UNICAST   = 2'b00,
    DST_MULTICAST = 2'b01,
    DST_BROADCAST = 2'b10
  } dst_class_e;

  // Broadcast wins over the group bit; group bit alone means multicast.
  function automatic dst_class_e classify_dst(input logic [7:0] first_byte);
    if (first_byte == 8'hFF)  return DST_BROADCAST;
    else if (first_byte[0])   return DST_MULTICAST;
    else                      return DST_UNICAST;
  endfunction

  // Inclusive range test used for collision bins.
  function automatic logic in_range(input int unsigned val,
                                    input int unsigned lo,
                                    input int unsigned hi);
    return (val >= lo) && (val <= hi);
  endfunction

endpackage

// File: rtl/txstat_dst_class.sv
module txstat_dst_class
  import txstat_pkg::*;
(
  input  logic [7:0] first_byte,
  output logic       is_bcast,
  output logic       is_mcast
);

  dst_class_e cls;

  always_comb begin
    cls      = classify_dst(first_byte);
    is_bcast = (cls == DST_BROADCAST);
    is_mcast = (cls == DST_MULTICAST);
  end

endmodule

// File: rtl/txstat_coll_bin.sv
module txstat_coll_bin
  import txstat_pkg::*;
#(
  parameter int COLL_W    = 5,
  parameter int MULTI_MAX = 15
) (
  input  logic [COLL_W-1:0] coll_cnt,
  output logic              bin_single,
  output logic              bin_multi
);

  localparam int unsigned MULTI_LO = 2;

  always_comb begin
    bin_single = (int'(coll_cnt) == 1);
    bin_multi  = in_range(int'(coll_cnt), MULTI_LO, MULTI_MAX);
  end

endmodule

// File: rtl/txstat_classifier.sv
module txstat_classifier
  import txstat_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int COLL_W    = 5,
  parameter int MULTI_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [1:0]        rec_outcome,
  input  logic [COLL_W-1:0] rec_coll_cnt,
  input  logic              rec_deferred,
  input  logic              rec_excess_defer,
  input  logic              rec_carrier_lost,
  input  logic [7:0]        rec_dst_byte0,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic              late_coll_evt,
  output logic              inc_frames_ok,
  output logic              inc_bcast_ok,
  output logic              inc_mcast_ok,
  output logic              inc_octets_ok,
  output logic [LEN_W-1:0]  octet_amount,
  output logic              inc_single_coll,
  output logic              inc_multi_coll,
  output logic              inc_late_coll,
  output logic              inc_xs_coll_abort,
  output logic              inc_carrier_err,
  output logic              inc_deferred,
  output logic              inc_excess_defer
);

  // Named internal events, shared by the logic and the checks.
  logic        frame_ok;
  logic        frame_abort;
  logic        dst_bcast;
  logic        dst_mcast;
  logic        bin_single;
  logic        bin_multi;
  tx_outcome_e outcome;

  assign outcome     = tx_outcome_e'(rec_outcome);
  assign frame_ok    = rec_valid && (outcome == OUT_OK);
  assign frame_abort = rec_valid && (outcome == OUT_XS_COLL);

  txstat_dst_class u_dst (
    .first_byte (rec_dst_byte0),
    .is_bcast   (dst_bcast),
    .is_mcast   (dst_mcast)
  );

  txstat_coll_bin #(
    .COLL_W    (COLL_W),
    .MULTI_MAX (MULTI_MAX)
  ) u_coll (
    .coll_cnt   (rec_coll_cnt),
    .bin_single (bin_single),
    .bin_multi  (bin_multi)
  );

  always_comb begin
    inc_frames_ok     = frame_ok;
    inc_bcast_ok      = frame_ok && dst_bcast;
    inc_mcast_ok      = frame_ok && dst_mcast;
    inc_octets_ok     = frame_ok;
    octet_amount      = frame_ok ? rec_len : '0;
    inc_single_coll   = frame_ok && bin_single;
    inc_multi_coll    = frame_ok && bin_multi;
    inc_late_coll     = late_coll_evt;
    inc_xs_coll_abort = frame_abort;
    inc_carrier_err   = frame_ok && rec_carrier_lost;
    inc_deferred      = rec_valid && rec_deferred;
    inc_excess_defer  = rec_valid && rec_excess_defer;
  end

  // R1: a success record counts even when carrier was lost
  a_r1_ok_despite_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_outcome == 2'b00 && rec_carrier_lost) |-> inc_frames_ok);

  // R2: the two address classes are exclusive
  a_r2_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_bcast_ok && inc_mcast_ok));

  // R3: no octets are added without a success strobe
  a_r3_octet_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_octets_ok |-> (octet_amount == '0));

  // R4/R5: a frame lands in at most one collision bin
  a_r5_bins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_single_coll && inc_multi_coll));

  // R7: an aborted frame is never also a success
  a_r7_abort_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
    inc_xs_coll_abort |-> !inc_frames_ok);

  // R8: carrier errors are only reported for successful frames
  a_r8_carrier_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    inc_carrier_err |-> inc_frames_ok);

  // R10: without a record only the late strobe may move
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> !(inc_frames_ok || inc_xs_coll_abort || inc_deferred ||
                     inc_excess_defer || inc_single_coll || inc_multi_coll));

  // R6: every late-collision pulse is forwarded
  a_r6_late_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    late_coll_evt |-> inc_late_coll);

endmodule

// File: tb/txstat_classifier_bench.sv
module txstat_classifier_bench;

  localparam int LEN_W  = 16;
  localparam int COLL_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rec_valid = 1'b0;
  logic [1:0]        rec_outcome = 2'b00;
  logic [COLL_W-1:0] rec_coll_cnt = '0;
  logic              rec_deferred = 1'b0;
  logic              rec_excess_defer = 1'b0;
  logic              rec_carrier_lost = 1'b0;
  logic [7:0]        rec_dst_byte0 = 8'h00;
  logic [LEN_W-1:0]  rec_len = '0;
  logic              late_coll_evt = 1'b0;
  logic              inc_frames_ok, inc_bcast_ok, inc_mcast_ok, inc_octets_ok;
  logic [LEN_W-1:0]  octet_amount;
  logic              inc_single_coll, inc_multi_coll, inc_late_coll;
  logic              inc_xs_coll_abort, inc_carrier_err, inc_deferred, inc_excess_defer;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  txstat_classifier #(.LEN_W(LEN_W), .COLL_W(COLL_W)) u_txstat_classifier (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_outcome(rec_outcome),
    .rec_coll_cnt(rec_coll_cnt), .rec_deferred(rec_deferred),
    .rec_excess_defer(rec_excess_defer), .rec_carrier_lost(rec_carrier_lost),
    .rec_dst_byte0(rec_dst_byte0), .rec_len(rec_len), .late_coll_evt(late_coll_evt),
    .inc_frames_ok(inc_frames_ok), .inc_bcast_ok(inc_bcast_ok),
    .inc_mcast_ok(inc_mcast_ok), .inc_octets_ok(inc_octets_ok),
    .octet_amount(octet_amount), .inc_single_coll(inc_single_coll),
    .inc_multi_coll(inc_multi_coll), .inc_late_coll(inc_late_coll),
    .inc_xs_coll_abort(inc_xs_coll_abort), .inc_carrier_err(inc_carrier_err),
    .inc_deferred(inc_deferred), .inc_excess_defer(inc_excess_defer)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives one record at the falling edge, checks all outputs mid-cycle,
  // with expected values worked out from the requirements.
  task automatic send(input string req, input logic [1:0] oc, input int coll,
                      input bit dfr, input bit xdfr, input bit crs,
                      input logic [7:0] b0, input int len, input bit vld);
    bit ok, ab, bc, mc;
    @(negedge clk);
    rec_valid = vld; rec_outcome = oc; rec_coll_cnt = COLL_W'(coll);
    rec_deferred = dfr; rec_excess_defer = xdfr; rec_carrier_lost = crs;
    rec_dst_byte0 = b0; rec_len = LEN_W'(len);
    #2;
    ok = vld && (oc == 2'b00);
    ab = vld && (oc == 2'b01);
    bc = (b0 == 8'hFF);
    mc = !bc && (b0 % 2 == 1);
    chk({req, " R1"}, "frames_ok", inc_frames_ok, ok);
    chk({req, " R2"}, "bcast_ok", inc_bcast_ok, ok && bc);
    chk({req, " R2"}, "mcast_ok", inc_mcast_ok, ok && mc);
    chk({req, " R3"}, "octets_ok", inc_octets_ok, ok);
    chk({req, " R3"}, "octet_amount", octet_amount, ok ? len : 0);
    chk({req, " R4"}, "single_coll", inc_single_coll, ok && coll == 1);
    chk({req, " R5"}, "multi_coll", inc_multi_coll, ok && coll >= 2 && coll <= 15);
    chk({req, " R7"}, "xs_abort", inc_xs_coll_abort, ab);
    chk({req, " R8"}, "carrier_err", inc_carrier_err, ok && crs);
    chk({req, " R9"}, "deferred", inc_deferred, vld && dfr);
    chk({req, " R9"}, "excess_defer", inc_excess_defer, vld && xdfr);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic t_reset_state;
    #2;
    chk("R10", "idle frames_ok", inc_frames_ok, 0);
    chk("R10", "idle octet_amount", octet_amount, 0);
    chk("R6", "idle late", inc_late_coll, 0);
  endtask

  task automatic t_outcomes;  // R1, R7, R8
    for (int oc = 0; oc < 4; oc++)
      for (int c = 0; c < 2; c++)
        send("outcome", 2'(oc), 0, 0, 0, c[0], 8'h00, 64 + oc, 1'b1);
  endtask

  task automatic t_collisions;  // R4, R5
    int cs[5] = '{0, 1, 2, 15, 16};
    foreach (cs[i]) begin
      send("coll_ok", 2'b00, cs[i], 0, 0, 0, 8'h02, 100, 1'b1);
      send("coll_abort", 2'b01, cs[i], 0, 0, 0, 8'h02, 100, 1'b1);
    end
  endtask

  task automatic t_dest;  // R2, R3
    logic [7:0] bs[4] = '{8'hFF, 8'h01, 8'hFE, 8'h00};
    foreach (bs[i]) begin
      send("dest_ok", 2'b00, 0, 0, 0, 0, bs[i], 1518, 1'b1);
      send("dest_err", 2'b10, 0, 0, 0, 0, bs[i], 1518, 1'b1);
    end
    send("len_max", 2'b00, 0, 0, 0, 0, 8'h00, 65535, 1'b1);
  endtask

  task automatic t_defer;  // R9
    for (int oc = 0; oc < 4; oc++) begin
      send("defer", 2'(oc), 0, 1, 0, 0, 8'h00, 60, 1'b1);
      send("xdefer", 2'(oc), 0, 0, 1, 0, 8'h00, 60, 1'b1);
    end
  endtask

  task automatic t_idle;  // R10
    send("idle", 2'b00, 1, 1, 1, 1, 8'hFF, 1000, 1'b0);
    send("idle", 2'b01, 3, 1, 1, 1, 8'h01, 1000, 1'b0);
  endtask

  task automatic t_late;  // R6
    @(negedge clk);
    late_coll_evt = 1'b1; #2;
    chk("R6", "late no record", inc_late_coll, 1);
    chk("R10", "late no record frames_ok", inc_frames_ok, 0);
    @(negedge clk); #2;
    chk("R6", "late back-to-back", inc_late_coll, 1);
    @(negedge clk);
    late_coll_evt = 1'b0; #2;
    chk("R6", "late released", inc_late_coll, 0);
    @(negedge clk);
    late_coll_evt = 1'b1; rec_valid = 1'b1; rec_outcome = 2'b00; #2;
    chk("R6", "late with record", inc_late_coll, 1);
    @(negedge clk);
    late_coll_evt = 1'b0; rec_valid = 1'b0;
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_outcomes();
    t_collisions();
    t_dest();
    t_defer();
    t_idle();
    t_late();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule